// File: doc/BRIEF.md
# Flash bank dual-operation controller

This block decides, request by request, what a multi-bank flash array may do while a program or erase is under way. Each request carries an opcode and a 23-bit word address; the controller splits the address into a bank number and an erase-block number. It records which bank holds the single running program or erase, and whether that operation is suspended. It answers every request one cycle later with accept, reject or wait. For reads it also says whether the word returned should be array data or the status register. A separate timer, outside the block, signals when the running operation has finished.

Suspension follows the flash rules. A suspended program lets any other word be read. A suspended erase lets any other block be read or programmed. Only one such nested program may run inside a suspended erase, and a resume must wait until that program finishes. Reads that stream across a bank edge are judged word by word, so the bank under operation gives status and its neighbour gives data.

Top module: `flash_dualop_ctrl`

## Requirements
- R1: Bank = address bits [22:19]. For banks 0 to 14 the block index is bank*8 + address bits [18:16].
- R2: Bank 15 is the parameter bank. When bits [18:16] are below 7, the block index is 120 + bits [18:16]. When bits [18:16] are 7, the block index is 127 + bits [15:14], so the highest block is 130.
- R3: Each request cycle gives exactly one response in the following cycle (rsp_valid high for one cycle), with no response otherwise. Response codes are 0 = accept, 1 = reject, 2 = wait. Opcodes are 0 read, 1 program, 2 erase, 3 suspend, 4 resume, and any other opcode is rejected.
- R4: A program or erase is accepted only when idle, which makes the controller busy on that bank. The one exception is the program allowed in R8. Any other program or erase while busy or suspended is rejected.
- R5: Reads are always accepted. While an operation runs, a read of its bank has rsp_status_sel = 1 and a read of any other bank has 0. When idle every read has 0.
- R6: A suspend is accepted only while a program or erase is running, and moves the status to suspended. In any other case it is rejected.
- R7: While a program is suspended, only a read of the exact suspended address has rsp_status_sel = 1.
- R8: While an erase is suspended, a program to a different block is accepted and makes the controller busy on that program's bank. A program to the suspended block is rejected. Reads of the suspended block, and of the nested program's bank, give status.
- R9: A resume from a suspended state is accepted and returns to busy on the original bank. A resume during a nested program answers wait and changes nothing. A resume in any other case is rejected.
- R10: Completion ends a running operation (busy to idle). It ends a nested program and returns to erase-suspended. It is ignored when idle or suspended. Completion in the same cycle as a request is applied before the request is judged.
- R11: ctrl_status encodes 0 idle, 1 busy, 2 suspended. pe_bank is the bank of the operation in progress (the nested program's bank while one runs) and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request opcode |
| req_addr | input | 23 | Word address of the request |
| pe_done | input | 1 | Completion pulse from the program/erase timer |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Accept, reject or wait |
| rsp_status_sel | output | 1 | Read returns the status register instead of array data |
| rsp_bank | output | 4 | Decoded bank of the answered request |
| rsp_blk | output | 8 | Decoded block index of the answered request |
| ctrl_status | output | 2 | Idle, busy or suspended |
| pe_bank | output | 4 | Bank of the operation in progress |

## Verification
The bench aims at the decode edges: the last word of bank 14, and each of the four small blocks at the top of the parameter bank. A decoder that ignored the split would put three small blocks on index 127. It streams reads across the boundary of the busy bank; a controller that judged by block or by the previous word would give status from the wrong bank. It tries a program into the block of a suspended erase, a resume during a nested program, and completion pulses when nothing runs. A design that mishandled these would overwrite the erase target, drop the nested program, or leave the suspended state. Completion arriving together with a suspend or an erase checks that completion is applied first; a design that got the order wrong would accept a suspend of a finished operation or refuse a legal erase.

// File: rtl/flashdo_pkg.sv
package flashdo_pkg;
   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_SUSP   = 3'd3,
      OP_RESUME = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      RSP_ACCEPT = 2'd0,
      RSP_REJECT = 2'd1,
      RSP_WAIT   = 2'd2
   } rsp_e;

   typedef enum logic [1:0] {
      STAT_IDLE = 2'd0,
      STAT_BUSY = 2'd1,
      STAT_SUSP = 2'd2
   } stat_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PROG,
      S_ERASE,
      S_PSUSP,
      S_ESUSP,
      S_ESUSP_PROG
   } fsm_e;
endpackage

// File: rtl/flashdo_addr_decode.sv
module flashdo_addr_decode #(
   parameter int ADDR_W       = 23,
   parameter int BANK_W       = 4,
   parameter int MBLK_W       = 3,
   parameter int SPLIT_W      = 2,
   parameter int BLKIDX_W     = 8,
   parameter bit PARAM_AT_TOP = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [BANK_W-1:0]   bank,
   output logic [BLKIDX_W-1:0] blk
);
   localparam int BANK_LSB = ADDR_W - BANK_W;
   localparam int MBLK_LSB = BANK_LSB - MBLK_W;
   localparam int NBANK    = 1 << BANK_W;
   localparam int NMBLK    = 1 << MBLK_W;
   localparam int NSPLIT   = 1 << SPLIT_W;
   localparam int NBLK     = NBANK * NMBLK + NSPLIT - 1;

   if (MBLK_LSB - SPLIT_W < 0) begin : g_bad_split
      $error("address too narrow for bank, block and split fields");
   end
   if ((1 << BLKIDX_W) < NBLK) begin : g_bad_idx
      $error("BLKIDX_W too small for block count");
   end

   logic [MBLK_W-1:0]   mblk;
   logic [SPLIT_W-1:0]  split;
   logic [BLKIDX_W-1:0] base;

   assign bank  = addr[ADDR_W-1 -: BANK_W];
   assign mblk  = addr[BANK_LSB-1 -: MBLK_W];
   assign split = addr[MBLK_LSB-1 -: SPLIT_W];
   assign base  = BLKIDX_W'({bank, mblk});

   if (PARAM_AT_TOP) begin : g_param_top
      always_comb begin
         blk = base;
         if (bank == BANK_W'(NBANK - 1) && mblk == MBLK_W'(NMBLK - 1))
            blk = base + BLKIDX_W'(split);
      end
   end else begin : g_param_bottom
      always_comb begin
         if (bank == '0 && mblk == '0)
            blk = BLKIDX_W'(split);
         else
            blk = base + BLKIDX_W'(NSPLIT - 1);
      end
   end

   always_comb begin
      if (!$isunknown(addr))
         AST_BLK_RANGE: assert (int'(blk) < NBLK); // R2
   end
endmodule

// File: rtl/flashdo_pe_fsm.sv
module flashdo_pe_fsm
   import flashdo_pkg::*;
#(
   parameter int ADDR_W   = 23,
   parameter int BANK_W   = 4,
   parameter int BLKIDX_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [BANK_W-1:0]   req_bank,
   input  logic [BLKIDX_W-1:0] req_blk,
   input  logic                pe_done,
   output logic                rsp_valid,
   output logic [1:0]          rsp_code,
   output logic                rsp_status_sel,
   output logic [1:0]          ctrl_status,
   output logic [BANK_W-1:0]   pe_bank
);
   fsm_e                st, eff, nxt;
   rsp_e                code;
   logic                stat_sel, cap_tgt, cap_nest;
   logic [ADDR_W-1:0]   tgt_addr;
   logic [BANK_W-1:0]   tgt_bank, nest_bank;
   logic [BLKIDX_W-1:0] tgt_blk;

   // completion is applied before the request is judged
   always_comb begin
      eff = st;
      case (st)
         S_PROG, S_ERASE: if (pe_done) eff = S_IDLE;
         S_ESUSP_PROG:    if (pe_done) eff = S_ESUSP;
         default: ;
      endcase
   end

   always_comb begin
      nxt      = eff;
      code     = RSP_REJECT;
      stat_sel = 1'b0;
      cap_tgt  = 1'b0;
      cap_nest = 1'b0;
      if (req_valid) begin
         case (req_op)
            OP_READ: begin
               code = RSP_ACCEPT;
               case (eff)
                  S_PROG, S_ERASE: stat_sel = (req_bank == tgt_bank);
                  S_PSUSP:         stat_sel = (req_addr == tgt_addr);
                  S_ESUSP:         stat_sel = (req_blk == tgt_blk);
                  S_ESUSP_PROG:    stat_sel = (req_bank == nest_bank) || (req_blk == tgt_blk);
                  default:         stat_sel = 1'b0;
               endcase
            end
            OP_PROG: begin
               if (eff == S_IDLE) begin
                  code = RSP_ACCEPT; nxt = S_PROG; cap_tgt = 1'b1;
               end else if (eff == S_ESUSP && req_blk != tgt_blk) begin
                  code = RSP_ACCEPT; nxt = S_ESUSP_PROG; cap_nest = 1'b1;
               end
            end
            OP_ERASE: begin
               if (eff == S_IDLE) begin
                  code = RSP_ACCEPT; nxt = S_ERASE; cap_tgt = 1'b1;
               end
            end
            OP_SUSP: begin
               if (eff == S_PROG) begin
                  code = RSP_ACCEPT; nxt = S_PSUSP;
               end else if (eff == S_ERASE) begin
                  code = RSP_ACCEPT; nxt = S_ESUSP;
               end
            end
            OP_RESUME: begin
               if (eff == S_PSUSP) begin
                  code = RSP_ACCEPT; nxt = S_PROG;
               end else if (eff == S_ESUSP) begin
                  code = RSP_ACCEPT; nxt = S_ERASE;
               end else if (eff == S_ESUSP_PROG) begin
                  code = RSP_WAIT;
               end
            end
            default: code = RSP_REJECT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= S_IDLE;
         tgt_addr       <= '0;
         tgt_bank       <= '0;
         tgt_blk        <= '0;
         nest_bank      <= '0;
         rsp_valid      <= 1'b0;
         rsp_code       <= RSP_REJECT;
         rsp_status_sel <= 1'b0;
      end else begin
         st             <= nxt;
         rsp_valid      <= req_valid;
         rsp_code       <= code;
         rsp_status_sel <= stat_sel;
         if (cap_tgt) begin
            tgt_addr <= req_addr;
            tgt_bank <= req_bank;
            tgt_blk  <= req_blk;
         end
         if (cap_nest) nest_bank <= req_bank;
      end
   end

   always_comb begin
      case (st)
         S_IDLE:           ctrl_status = STAT_IDLE;
         S_PSUSP, S_ESUSP: ctrl_status = STAT_SUSP;
         default:          ctrl_status = STAT_BUSY;
      endcase
      if (st == S_IDLE)            pe_bank = '0;
      else if (st == S_ESUSP_PROG) pe_bank = nest_bank;
      else                         pe_bank = tgt_bank;
   end

   AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R3
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R3
   AST_PE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == OP_PROG || req_op == OP_ERASE) && ctrl_status == STAT_BUSY && !pe_done)
      |=> rsp_code == RSP_REJECT); // R4
   AST_IDLE_READ_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_READ && ctrl_status == STAT_IDLE) |=> !rsp_status_sel); // R5
   AST_SUSP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SUSP && ctrl_status != STAT_BUSY) |=> rsp_code == RSP_REJECT); // R6
   AST_WAIT_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_WAIT) |-> ctrl_status == STAT_BUSY); // R9
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_PROG || st == S_ERASE) && pe_done && !req_valid) |=> ctrl_status == STAT_IDLE); // R10
endmodule

// File: rtl/flash_dualop_ctrl.sv
module flash_dualop_ctrl #(
   parameter int ADDR_W       = 23,
   parameter int BANK_W       = 4,
   parameter int MBLK_W       = 3,
   parameter int SPLIT_W      = 2,
   parameter int BLKIDX_W     = 8,
   parameter bit PARAM_AT_TOP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [2:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                pe_done,
   output logic                rsp_valid,
   output logic [1:0]          rsp_code,
   output logic                rsp_status_sel,
   output logic [BANK_W-1:0]   rsp_bank,
   output logic [BLKIDX_W-1:0] rsp_blk,
   output logic [1:0]          ctrl_status,
   output logic [BANK_W-1:0]   pe_bank
);
   logic [BANK_W-1:0]   dec_bank;
   logic [BLKIDX_W-1:0] dec_blk;

   flashdo_addr_decode #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MBLK_W(MBLK_W), .SPLIT_W(SPLIT_W),
      .BLKIDX_W(BLKIDX_W), .PARAM_AT_TOP(PARAM_AT_TOP)
   ) u_decode (
      .addr (req_addr),
      .bank (dec_bank),
      .blk  (dec_blk)
   );

   flashdo_pe_fsm #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLKIDX_W(BLKIDX_W)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_op         (req_op),
      .req_addr       (req_addr),
      .req_bank       (dec_bank),
      .req_blk        (dec_blk),
      .pe_done        (pe_done),
      .rsp_valid      (rsp_valid),
      .rsp_code       (rsp_code),
      .rsp_status_sel (rsp_status_sel),
      .ctrl_status    (ctrl_status),
      .pe_bank        (pe_bank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_bank <= '0;
         rsp_blk  <= '0;
      end else begin
         rsp_bank <= dec_bank;
         rsp_blk  <= dec_blk;
      end
   end
endmodule

// File: tb/flash_dualop_ctrl_bench.sv
`timescale 1ns/1ps
module flash_dualop_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [22:0] req_addr = '0;
   logic        pe_done = 1'b0;
   logic        rsp_valid, rsp_status_sel;
   logic [1:0]  rsp_code, ctrl_status;
   logic [3:0]  rsp_bank, pe_bank;
   logic [7:0]  rsp_blk;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   typedef struct packed {
      logic [1:0] code;
      logic       stat;
      logic [3:0] bank;
      logic [7:0] blk;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   flash_dualop_ctrl u_flash_dualop_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .pe_done(pe_done), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .rsp_status_sel(rsp_status_sel), .rsp_bank(rsp_bank),
      .rsp_blk(rsp_blk), .ctrl_status(ctrl_status), .pe_bank(pe_bank)
   );

   // block index from R1/R2
   function automatic logic [7:0] exp_blk(input logic [22:0] a);
      logic [3:0] b = a[22:19];
      logic [2:0] m = a[18:16];
      if (b != 4'd15) return 8'(b * 8 + m);
      if (m != 3'd7)  return 8'(120 + m);
      return 8'(127 + a[15:14]);
   endfunction

   // monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t  e;
         string t;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3: response with nothing expected, actual code=%0d expected none", rsp_code);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_code !== e.code || rsp_status_sel !== e.stat ||
                rsp_bank !== e.bank || rsp_blk !== e.blk) begin
               errors++;
               $display("FAIL %s: actual code=%0d stat=%0d bank=%0d blk=%0d expected code=%0d stat=%0d bank=%0d blk=%0d",
                        t, rsp_code, rsp_status_sel, rsp_bank, rsp_blk, e.code, e.stat, e.bank, e.blk);
            end
         end
      end
   end

   task automatic send(input logic [2:0] op, input logic [22:0] a, input logic dn,
                       input logic [1:0] ec, input logic es, input string tag);
      exp_t e;
      e.code = ec; e.stat = es; e.bank = a[22:19]; e.blk = exp_blk(a);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req_valid = 1'b1; req_op = op; req_addr = a; pe_done = dn;
      @(negedge clk);
      req_valid = 1'b0; pe_done = 1'b0;
   endtask

   task automatic done_pulse();
      pe_done = 1'b1;
      @(negedge clk);
      pe_done = 1'b0;
   endtask

   task automatic chk_status(input logic [1:0] es, input logic [3:0] eb, input string tag);
      checks++;
      if (ctrl_status !== es || pe_bank !== eb) begin
         errors++;
         $display("FAIL %s: actual status=%0d pe_bank=%0d expected status=%0d pe_bank=%0d",
                  tag, ctrl_status, pe_bank, es, eb);
      end
   endtask

   localparam logic [2:0] RD = 3'd0, PG = 3'd1, ER = 3'd2, SU = 3'd3, RE = 3'd4;
   localparam logic [1:0] ACC = 2'd0, REJ = 2'd1, WT = 2'd2;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_status(2'd0, 4'd0, "R11 reset");
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R3 reset: actual rsp_valid=%0d expected 0", rsp_valid);
      end

      // R1 / R2 decode while idle
      send(RD, 23'h000000, 0, ACC, 0, "R1 bank0");
      send(RD, 23'h2D1234, 0, ACC, 0, "R1 bank5");
      send(RD, 23'h77FFFF, 0, ACC, 0, "R1 bank14 last");
      send(RD, 23'h780000, 0, ACC, 0, "R2 param first");
      send(RD, 23'h7EFFFF, 0, ACC, 0, "R2 param blk126");
      send(RD, 23'h7F0000, 0, ACC, 0, "R2 small 127");
      send(RD, 23'h7F4000, 0, ACC, 0, "R2 small 128");
      send(RD, 23'h7F8000, 0, ACC, 0, "R2 small 129");
      send(RD, 23'h7FFFFF, 0, ACC, 0, "R2 small 130");
      send(3'd7, 23'h000000, 0, REJ, 0, "R3 bad opcode");
      send(SU, 23'h000000, 0, REJ, 0, "R6 suspend idle");
      send(RE, 23'h000000, 0, REJ, 0, "R9 resume idle");
      done_pulse();
      chk_status(2'd0, 4'd0, "R10 done idle ignored");

      // erase in bank 2, block 18
      send(ER, 23'h123456, 0, ACC, 0, "R4 erase idle");
      chk_status(2'd1, 4'd2, "R11 busy bank2");
      send(PG, 23'h000010, 0, REJ, 0, "R4 prog while busy");
      send(ER, 23'h400000, 0, REJ, 0, "R4 erase while busy");
      send(RD, 23'h120000, 0, ACC, 1, "R5 read busy bank");
      send(RD, 23'h080000, 0, ACC, 0, "R5 read other bank");
      send(RD, 23'h0FFFFF, 0, ACC, 0, "R5 burst bank1 end");
      send(RD, 23'h100000, 0, ACC, 1, "R5 burst bank2 start");
      send(RE, 23'h000000, 0, REJ, 0, "R9 resume while running");
      send(SU, 23'h000000, 0, ACC, 0, "R6 suspend erase");
      chk_status(2'd2, 4'd2, "R6 suspended");
      send(RD, 23'h123000, 0, ACC, 1, "R8 read erase block");
      send(RD, 23'h110000, 0, ACC, 0, "R8 read same bank other blk");
      send(ER, 23'h500000, 0, REJ, 0, "R4 erase while suspended");
      send(PG, 23'h12FFFF, 0, REJ, 0, "R8 prog erase block");
      send(SU, 23'h000000, 0, REJ, 0, "R6 suspend while suspended");
      done_pulse();
      chk_status(2'd2, 4'd2, "R10 done suspended ignored");
      send(PG, 23'h300000, 0, ACC, 0, "R8 nested prog");
      chk_status(2'd1, 4'd6, "R8 busy nested bank");
      send(RD, 23'h300100, 0, ACC, 1, "R8 read nested bank");
      send(RD, 23'h123000, 0, ACC, 1, "R8 read erase block nested");
      send(RD, 23'h200000, 0, ACC, 0, "R8 read free bank");
      send(PG, 23'h000000, 0, REJ, 0, "R4 second nested prog");
      send(RE, 23'h000000, 0, WT, 0, "R9 resume waits");
      chk_status(2'd1, 4'd6, "R9 wait keeps state");
      done_pulse();
      chk_status(2'd2, 4'd2, "R10 nested done");
      send(RE, 23'h000000, 0, ACC, 0, "R9 resume erase");
      chk_status(2'd1, 4'd2, "R9 busy again");
      done_pulse();
      chk_status(2'd0, 4'd0, "R10 erase done");
      send(RD, 23'h123000, 0, ACC, 0, "R5 read after done");

      // program in bank 1, block 10
      send(PG, 23'h0ABCDE, 0, ACC, 0, "R4 prog idle");
      chk_status(2'd1, 4'd1, "R11 busy bank1");
      send(SU, 23'h000000, 0, ACC, 0, "R6 suspend prog");
      send(RD, 23'h0ABCDE, 0, ACC, 1, "R7 read prog addr");
      send(RD, 23'h0ABCDF, 0, ACC, 0, "R7 read neighbour");
      send(PG, 23'h0ABCDF, 0, REJ, 0, "R4 prog in prog suspend");
      send(RE, 23'h000000, 0, ACC, 0, "R9 resume prog");
      chk_status(2'd1, 4'd1, "R9 prog busy");
      send(SU, 23'h000000, 1, REJ, 0, "R10 done before suspend");
      chk_status(2'd0, 4'd0, "R10 idle after done");

      // completion and new erase in the same cycle
      send(ER, 23'h7FC000, 0, ACC, 0, "R4 erase param small");
      chk_status(2'd1, 4'd15, "R11 busy bank15");
      send(ER, 23'h000000, 1, ACC, 0, "R10 done before erase");
      chk_status(2'd1, 4'd0, "R10 new erase bank0");
      done_pulse();
      chk_status(2'd0, 4'd0, "R10 final idle");

      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R3: %0d responses missing, expected 0", exp_q.size());
      end
      done_flag = 1'b1;
   end

   initial begin
      fork
         wait (done_flag);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule